// File: doc/BRIEF.md
# Banked Column-Buffer Data Cache

This block is a 16 KB data cache whose storage is the set of line buffers that sit next to the DRAM banks. There are sixteen independent banks. Each bank has two 512-byte line buffers, and those two buffers are the two ways of that bank's single set. A processor load/store port carries 64-bit words with byte enables. A hit completes in the cycle it is presented. A miss stalls the processor until the line has been fetched.

The array side works on whole lines. On a miss the block issues one line read. It captures the complete 512-byte line exactly at the fixed array latency. If the displaced line is dirty, the block hands that line out as a full-width writeback in the same cycle as the read request. A dirty victim therefore never adds time to the miss. The testbench stands in for the DRAM array.

Top module: `colbuf_dcache`

## Requirements
- R1: Address fields are decoded as follows: bits [2:0] are the byte in the word, and the request must be word-aligned (zero). Bits [8:3] select one of 64 words in the line. Bits [12:9] select the bank. Bits [31:13] form the tag. The line address on both array ports is {tag, bank}, which is request bits [31:9].
- R2: A load that hits drives `rsp_valid` high with the stored word on `rsp_rdata` in the same cycle, with `req_stall` low.
- R3: A miss raises `req_stall` in the request cycle and keeps it high for ARRAY_LAT+1 cycles in total (7 by default). `arr_rd_valid` pulses only in the first of those cycles, and the access completes as a hit in the cycle after.
- R4: The refill line is captured from `arr_rd_line` only in the cycle ARRAY_LAT cycles after the read request cycle. Word w of the line occupies bits [64w+63:64w].
- R5: Each bank has one replacement bit, which is 0 after reset. A miss replaces the way that bit names. Every hit and every fill sets the bit to the other way.
- R6: A store hit updates only the bytes whose enable is set, and marks the line dirty. Enable bit i covers data bits [8i+7:8i]. A store with no enables changes nothing.
- R7: A store miss first fills the line (write-allocate) and then merges the store into it.
- R8: When the victim way is valid and dirty, `arr_wr_valid` is high in the same cycle as `arr_rd_valid`. `arr_wr_addr` then carries the victim's line address and `arr_wr_line` the whole victim line, laid out as in R4. A clean or empty victim produces no writeback.
- R9: After reset no line is valid, so the first access to any address misses. No array request and no stall occur while the port is idle.
- R10: Misses, fills and stores in one bank leave the contents and state of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, held while stalled |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address, word-aligned |
| req_be | input | 8 | Store byte enables |
| req_wdata | input | 64 | Store data |
| req_stall | output | 1 | Access not completed this cycle |
| rsp_valid | output | 1 | Access completes this cycle |
| rsp_rdata | output | 64 | Load data (word before any store merge) |
| arr_rd_valid | output | 1 | Line read request pulse |
| arr_rd_addr | output | 23 | Line address to read |
| arr_rd_line | input | 4096 | Line data from the array |
| arr_wr_valid | output | 1 | Line writeback pulse |
| arr_wr_addr | output | 23 | Line address to write |
| arr_wr_line | output | 4096 | Line data to write |

## Verification
The bench first targets a single bank with a hand-built sequence: fill, hit, partial store, second-way fill, LRU-directed eviction, then dirty eviction and refetch. Whether a clean or a dirty line gets written back shows whether the replacement bit is correct. A store miss and a store with no byte enables separate write-allocate from merge behaviour. Traffic interleaved across banks 0, 3 and 15, followed by hits on earlier lines, shows that the banks are independent. The array model drives valid line data only in the capture cycle, so any error in fill timing shows up as corrupted loads. A stretch of pseudo-random loads and stores over a few tags and banks, compared against a reference model of the cache state, covers orderings that the fixed sequence does not reach.

// File: rtl/colbuf_dcache.sv
`timescale 1ns/1ps
module colbuf_dcache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int NUM_BANKS  = 16,
  parameter int LINE_BYTES = 512,
  parameter int ARRAY_LAT  = 6
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  input  logic                                   req_write,
  input  logic [ADDR_W-1:0]                      req_addr,
  input  logic [DATA_W/8-1:0]                    req_be,
  input  logic [DATA_W-1:0]                      req_wdata,
  output logic                                   req_stall,
  output logic                                   rsp_valid,
  output logic [DATA_W-1:0]                      rsp_rdata,
  output logic                                   arr_rd_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   arr_rd_addr,
  input  logic [LINE_BYTES*8-1:0]                arr_rd_line,
  output logic                                   arr_wr_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   arr_wr_addr,
  output logic [LINE_BYTES*8-1:0]                arr_wr_line
);
  localparam int BE_W      = DATA_W / 8;
  localparam int BYTE_BITS = $clog2(BE_W);
  localparam int WORDS     = LINE_BYTES * 8 / DATA_W;
  localparam int WORD_BITS = $clog2(WORDS);
  localparam int BANK_BITS = $clog2(NUM_BANKS);
  localparam int OFF_BITS  = BYTE_BITS + WORD_BITS;
  localparam int TAG_W     = ADDR_W - OFF_BITS - BANK_BITS;
  localparam int CNT_W     = $clog2(ARRAY_LAT + 1);

  logic [DATA_W-1:0] mem_q   [NUM_BANKS][2][WORDS];
  logic [TAG_W-1:0]  tag_q   [NUM_BANKS][2];
  logic [1:0]        val_q   [NUM_BANKS];
  logic [1:0]        dirty_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] lru_q;

  logic                 waiting_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [BANK_BITS-1:0] mbank_q;
  logic                 mway_q;
  logic [TAG_W-1:0]     mtag_q;

  wire [BANK_BITS-1:0] bank = req_addr[OFF_BITS +: BANK_BITS];
  wire [WORD_BITS-1:0] word = req_addr[BYTE_BITS +: WORD_BITS];
  wire [TAG_W-1:0]     tag  = req_addr[ADDR_W-1 -: TAG_W];

  wire hit0    = val_q[bank][0] && (tag_q[bank][0] == tag);
  wire hit1    = val_q[bank][1] && (tag_q[bank][1] == tag);
  wire hit     = hit0 || hit1;
  wire hit_way = hit1;
  wire vway    = lru_q[bank];
  wire fill_now = waiting_q && (cnt_q == '0);

  assign req_stall    = req_valid && (waiting_q || !hit);
  assign rsp_valid    = req_valid && !req_stall;
  assign rsp_rdata    = mem_q[bank][hit_way][word];
  assign arr_rd_valid = req_valid && !waiting_q && !hit;
  assign arr_rd_addr  = req_addr[ADDR_W-1:OFF_BITS];
  assign arr_wr_valid = arr_rd_valid && val_q[bank][vway] && dirty_q[bank][vway];
  assign arr_wr_addr  = {tag_q[bank][vway], bank};

  always_comb begin
    for (int w = 0; w < WORDS; w++)
      arr_wr_line[w*DATA_W +: DATA_W] = mem_q[bank][vway][w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lru_q     <= '0;
      waiting_q <= 1'b0;
      cnt_q     <= '0;
      mbank_q   <= '0;
      mway_q    <= 1'b0;
      mtag_q    <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        val_q[b]    <= '0;
        dirty_q[b]  <= '0;
        tag_q[b][0] <= '0;
        tag_q[b][1] <= '0;
      end
    end else begin
      if (arr_rd_valid) begin
        waiting_q <= 1'b1;
        cnt_q     <= CNT_W'(ARRAY_LAT - 1);
        mbank_q   <= bank;
        mway_q    <= vway;
        mtag_q    <= tag;
      end else if (waiting_q) begin
        if (fill_now) begin
          waiting_q                <= 1'b0;
          tag_q[mbank_q][mway_q]   <= mtag_q;
          val_q[mbank_q][mway_q]   <= 1'b1;
          dirty_q[mbank_q][mway_q] <= 1'b0;
          lru_q[mbank_q]           <= ~mway_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (rsp_valid) begin
        lru_q[bank] <= ~hit_way;
        if (req_write) dirty_q[bank][hit_way] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_now)
      for (int w = 0; w < WORDS; w++)
        mem_q[mbank_q][mway_q][w] <= arr_rd_line[w*DATA_W +: DATA_W];
    if (rsp_valid && req_write)
      for (int i = 0; i < BE_W; i++)
        if (req_be[i]) mem_q[bank][hit_way][word][i*8 +: 8] <= req_wdata[i*8 +: 8];
  end

  // R1
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[BYTE_BITS-1:0] == '0));

  // R3
  rd_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_valid |=> !arr_rd_valid);

  // R3
  no_rsp_during_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_valid |=> !rsp_valid);

  // R5
  way_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit0, hit1}));

  // R6
  dirty_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_write) |=> dirty_q[$past(bank)][$past(hit_way)]);

  // R8
  wb_addr_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_valid |-> (arr_wr_addr != arr_rd_addr));
endmodule

// File: tb/colbuf_dcache_test.sv
`timescale 1ns/1ps
module colbuf_dcache_test;
  localparam int LAT = 6;
  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0;
  logic [7:0] req_be = 0;
  logic [63:0] req_wdata = 0;
  logic req_stall, rsp_valid;
  logic [63:0] rsp_rdata;
  logic arr_rd_valid, arr_wr_valid;
  logic [22:0] arr_rd_addr, arr_wr_addr;
  logic [4095:0] arr_rd_line, arr_wr_line;

  localparam logic [4095:0] JUNK = {64{64'hDEAD_BEEF_0BAD_F00D}};

  colbuf_dcache uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  logic [63:0] refm [longint unsigned];
  function automatic logic [63:0] ref_word(longint unsigned wa);
    if (refm.exists(wa)) return refm[wa];
    return {8'hA5, 7'h0, wa[28:6], 20'h0, wa[5:0]};
  endfunction
  function automatic logic [4095:0] line_of(logic [22:0] la);
    logic [4095:0] l;
    for (int w = 0; w < 64; w++) l[w*64 +: 64] = ref_word({la, 6'(w)});
    return l;
  endfunction

  logic [18:0] mt [16][2];
  bit mv [16][2];
  bit md [16][2];
  bit ml [16];

  logic [63:0] exp_q [$];
  string lbl_q [$];

  int rd_seen = 0, wb_seen = 0;
  logic [22:0] last_rd, last_wb;
  logic [22:0] pend_la;
  int cnt = 0;

  always @(negedge clk) if (rst_n) begin
    if (rsp_valid && !req_write) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected response", rsp_rdata, 0);
      else begin
        logic [63:0] e;
        string l;
        e = exp_q.pop_front();
        l = lbl_q.pop_front();
        chk(rsp_rdata === e, l, rsp_rdata, e);
      end
    end
    if (arr_rd_valid) begin
      rd_seen++;
      last_rd = arr_rd_addr;
      pend_la = arr_rd_addr;
      cnt = LAT;
    end
    if (arr_wr_valid) begin
      logic [4095:0] el;
      wb_seen++;
      last_wb = arr_wr_addr;
      chk(arr_rd_valid === 1'b1, "R8 writeback without refill", 64'(arr_rd_valid), 1);
      el = line_of(arr_wr_addr);
      if (arr_wr_line !== el) begin
        for (int w = 0; w < 64; w++)
          if (arr_wr_line[w*64 +: 64] !== el[w*64 +: 64]) begin
            chk(0, "R8 writeback line", arr_wr_line[w*64 +: 64], el[w*64 +: 64]);
            break;
          end
      end else chk(1, "R8", 0, 0);
    end
  end

  always @(posedge clk) begin
    #1;
    if (cnt > 0) begin
      cnt--;
      arr_rd_line = (cnt == 0) ? line_of(pend_la) : JUNK;
    end else arr_rd_line = JUNK;
  end

  function automatic logic [31:0] mk(logic [18:0] t, logic [3:0] b, logic [5:0] w);
    return {t, b, w, 3'b000};
  endfunction

  task automatic access(bit wr, logic [31:0] a, logic [63:0] d, logic [7:0] be, string rq);
    logic [3:0] b;
    logic [18:0] t;
    bit h, hw, ewb;
    logic [22:0] ewa;
    int stalls, rd0, wb0;
    b = a[12:9];
    t = a[31:13];
    ewb = 0;
    ewa = '0;
    h = 0;
    hw = 0;
    for (int k = 0; k < 2; k++)
      if (mv[b][k] && mt[b][k] == t) begin h = 1; hw = k[0]; end
    if (!h) begin
      hw = ml[b];
      ewb = mv[b][hw] && md[b][hw];
      ewa = {mt[b][hw], b};
      mt[b][hw] = t; mv[b][hw] = 1; md[b][hw] = 0;
    end
    ml[b] = ~hw;
    if (wr) md[b][hw] = 1;
    if (!wr) begin
      exp_q.push_back(ref_word(longint'(a >> 3)));
      lbl_q.push_back({rq, " load data"});
    end
    rd0 = rd_seen;
    wb0 = wb_seen;
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    stalls = 0;
    forever begin
      @(negedge clk);
      if (!req_stall) break;
      stalls++;
      if (stalls > 100) break;
    end
    chk(stalls == (h ? 0 : LAT + 1), {rq, " R3 stall cycles"}, 64'(stalls), 64'(h ? 0 : LAT + 1));
    chk(rd_seen - rd0 == (h ? 0 : 1), {rq, " R3 line reads"}, 64'(rd_seen - rd0), 64'(h ? 0 : 1));
    if (!h) chk(last_rd == a[31:9], {rq, " R1 read line address"}, 64'(last_rd), 64'(a[31:9]));
    chk(wb_seen - wb0 == int'(ewb), {rq, " R8 writebacks"}, 64'(wb_seen - wb0), 64'(ewb));
    if (ewb) chk(last_wb == ewa, {rq, " R8 writeback address"}, 64'(last_wb), 64'(ewa));
    if (wr) begin
      logic [63:0] o;
      o = ref_word(longint'(a >> 3));
      for (int i = 0; i < 8; i++) if (be[i]) o[i*8 +: 8] = d[i*8 +: 8];
      refm[longint'(a >> 3)] = o;
    end
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    arr_rd_line = JUNK;
    for (int b = 0; b < 16; b++) begin
      ml[b] = 0;
      for (int k = 0; k < 2; k++) begin mv[b][k] = 0; md[b][k] = 0; mt[b][k] = 0; end
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_stall === 0 && rsp_valid === 0, "R9 idle after reset", {62'b0, req_stall, rsp_valid}, 0);
    chk(arr_rd_valid === 0 && arr_wr_valid === 0, "R9 no array request", {62'b0, arr_rd_valid, arr_wr_valid}, 0);

    access(0, mk(1, 0, 5), 0, 0, "R9 R4 first miss");
    access(0, mk(1, 0, 63), 0, 0, "R2 hit top word");
    access(0, mk(1, 0, 0), 0, 0, "R2 hit word 0");
    access(1, mk(1, 0, 5), 64'h1122_3344_5566_7788, 8'h0F, "R6 partial store hit");
    access(0, mk(1, 0, 5), 0, 0, "R6 merged readback");
    access(0, mk(2, 0, 1), 0, 0, "R5 second way fill");
    access(0, mk(1, 0, 5), 0, 0, "R5 hit way 0");
    access(0, mk(3, 0, 0), 0, 0, "R5 evict clean LRU way");
    access(0, mk(4, 0, 2), 0, 0, "R8 dirty eviction");
    access(0, mk(1, 0, 5), 0, 0, "R8 refetch written line");
    access(1, mk(5, 3, 7), 64'hCAFE_F00D_0000_0000, 8'hF0, "R7 store miss");
    access(0, mk(5, 3, 7), 0, 0, "R7 allocated merge");
    access(0, mk(7, 3, 0), 0, 0, "R10 bank 3 fill");
    access(0, mk(8, 3, 0), 0, 0, "R10 bank 3 dirty evict");
    access(0, mk(1, 0, 5), 0, 0, "R10 bank 0 undisturbed");
    access(1, mk(19'h7FFFF, 15, 63), 64'h0123_4567_89AB_CDEF, 8'hFF, "R1 top bank store miss");
    access(1, mk(19'h7FFFF, 15, 63), 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R6 no-enable store");
    access(0, mk(19'h7FFFF, 15, 63), 0, 0, "R6 no-enable unchanged");
    access(0, mk(0, 15, 0), 0, 0, "R5 top bank way 1");
    access(0, mk(1, 15, 0), 0, 0, "R8 top bank writeback");
    access(0, mk(19'h7FFFF, 15, 63), 0, 0, "R4 refetch top bank");

    r = 32'h1234_5678;
    for (int i = 0; i < 200; i++) begin
      logic [3:0] bb;
      r = r * 32'd1103515245 + 32'd12345;
      bb = (r[17:16] == 2'd3) ? 4'd15 : {2'b0, r[17:16]};
      access(r[22], mk(19'(r[21:20]) + 19'd1, bb, r[29:24]), {r, ~r}, r[11:4], "R2 random mix");
    end
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "R2 responses outstanding", 64'(exp_q.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule